// File: doc/BRIEF.md
# Filtering Multiprocessor Serial Receiver

This block receives asynchronous serial frames on a single line and hands completed characters to the logic that owns it. It relies on a sample tick from an outside rate generator that pulses 16 times per bit period. The line passes through a two-stage synchronizer. Each bit is then settled by a 2-of-3 vote over three samples taken around the bit centre, so a single corrupted sample does not change the result. A falling edge whose start bit is not confirmed low at the centre is treated as noise, and the receiver returns to idle.

A frame is a low start bit, 5 to 9 data bits sent least significant first, an optional address-marker bit, an optional parity bit, and one or two high stop bits. Each completed character is placed in a small receive buffer together with its own frame-error, parity-error and overrun flags. The receive-complete output stays high while any buffered character is unread. A one-cycle read strobe removes the oldest character.

In multiprocessor mode, several nodes share the line. Frames carrying a set marker bit are address frames. They are never buffered and only open or close this node's window. Data frames are kept only while the window is open.

Top module: `mp_serial_rx`

## Requirements
- R1: After reset, rx_valid is 0, and rx_data and all three error outputs read 0.
- R2: cfg_char_len values 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 data bits, and any value above 4 selects 9. Data arrives least significant bit first and appears in rx_data bit 0 upward, with unused upper bits of rx_data at 0.
- R3: Counting the first tick that sees the line low as sample 0 of the start bit, every bit is decided by a 2-of-3 vote over samples 6, 7 and 8 of its 16. Inverting only sample 7 of any bit leaves the received character unchanged.
- R4: When the start-bit vote is 1, no character is produced and the receiver returns to idle. A following correct frame is received normally.
- R5: With cfg_par_en set, one parity bit follows the data bits (and the marker bit, if present). It covers the data bits only: even parity when cfg_par_odd is 0, odd parity when it is 1. A mismatch stores the character with rx_par_err set. A match stores it with rx_par_err clear.
- R6: A first stop bit that votes 0 stores the character with rx_frame_err set, and its data is still delivered.
- R7: Only the first stop bit is examined. Frames sent back to back with two stop bits and no idle gap are all received without errors.
- R8: The buffer holds two characters. rx_valid stays 1 until every stored character has been read. rd_strobe removes the oldest character, and rd_strobe while empty has no effect.
- R9: A character that completes while both entries are full and no read occurs in the same cycle is discarded. The newest stored entry then gets its rx_overrun set; older entries keep theirs clear.
- R10: With cfg_mp_en set, one marker bit follows the data bits, and 1 marks an address frame. Address frames are never stored. An address frame with no error whose data bits 7:0 equal cfg_node_addr opens the window.
- R11: With cfg_mp_en set, data frames (marker 0) are stored only while the window is open. The window starts closed, and any address frame that does not match or carries a frame or parity error closes it.
- R12: With cfg_mp_en clear, no marker bit is expected and every completed frame is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Serial input, idle high |
| os_tick | input | 1 | One-cycle pulse, 16 per bit period |
| cfg_char_len | input | 3 | Data bit count code (0..4 = 5..9 bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_mp_en | input | 1 | Multiprocessor addressing mode |
| cfg_node_addr | input | 8 | This node's address |
| rd_strobe | input | 1 | Remove the oldest stored character |
| rx_data | output | 9 | Oldest stored character, 0 when empty |
| rx_valid | output | 1 | Receive complete: a character is unread |
| rx_frame_err | output | 1 | Frame error flag of the oldest character |
| rx_par_err | output | 1 | Parity error flag of the oldest character |
| rx_overrun | output | 1 | Overrun flag of the oldest character |

## Verification
Five properties are checked on every cycle:
- receive-complete is held until a read,
- the buffer fill never exceeds its depth,
- the engine returns to idle after a rejected start vote,
- an address frame never changes the fill,
- a completing frame that finds the buffer full does not change the fill.

The remaining behaviour can only be shown by the bench scenarios:
- the received values for each character length,
- the vote's immunity to a corrupted centre sample,
- the parity polarity,
- which entry takes the overrun flag,
- the order in which address frames open and close the window.

// File: rtl/mp_rx_pkg.sv
// Shared types for the multiprocessor serial receiver.
// Assumes a character never exceeds MAX_DATA bits.
package mp_rx_pkg;
    localparam int unsigned MAX_DATA = 9;
    localparam int unsigned MIN_DATA = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_MARK,
        S_PAR,
        S_STOP
    } rx_state_e;

    typedef struct packed {
        logic [MAX_DATA-1:0] data;
        logic                frame_err;
        logic                par_err;
        logic                overrun;
    } rx_entry_t;
endpackage

// File: rtl/rx_line_filter.sv
// Line conditioning: synchronizes the serial input and forms a 2-of-3
// majority vote over the three samples ending at the bit centre.
// Assumes: OS_RATE >= 4; phase comes from the frame engine.
module rx_line_filter #(
    parameter int unsigned OS_RATE     = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CW         = $clog2(OS_RATE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_in,
    input  logic          tick,
    input  logic [CW-1:0] phase,
    output logic          line_s,
    output logic          vote_vld,
    output logic          vote_bit
);
    localparam int unsigned MID = OS_RATE / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   samp_a;
    logic                   samp_b;

    // Synchronizer chain, reset to the idle (high) level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
    end

    assign line_s = sync_q[SYNC_STAGES-1];

    // Capture the two samples that precede the centre sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_a <= 1'b1;
            samp_b <= 1'b1;
        end else if (tick) begin
            if (phase == CW'(MID - 2)) samp_a <= line_s;
            if (phase == CW'(MID - 1)) samp_b <= line_s;
        end
    end

    // Majority of the two stored samples and the current one.
    always_comb begin
        vote_vld = tick && (phase == CW'(MID));
        vote_bit = (samp_a & samp_b) | (samp_a & line_s) | (samp_b & line_s);
    end
endmodule

// File: rtl/rx_frame_engine.sv
// Frame sequencer: detects the start edge, walks the start, data,
// marker, parity and first stop bit on filtered votes, and emits a
// one-cycle completion with the character and its checks.
// Assumes: OS_RATE is a power of two; configuration is stable within a frame.
module rx_frame_engine
    import mp_rx_pkg::*;
#(
    parameter int unsigned OS_RATE = 16,
    parameter int unsigned LEN_W   = 3,
    localparam int unsigned CW     = $clog2(OS_RATE),
    localparam int unsigned IW     = $clog2(MAX_DATA)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                line_s,
    input  logic                vote_vld,
    input  logic                vote_bit,
    input  logic [LEN_W-1:0]    cfg_char_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_mp_en,
    output logic [CW-1:0]       phase,
    output rx_state_e           state,
    output logic                done,
    output logic [MAX_DATA-1:0] done_data,
    output logic                done_mark,
    output logic                done_fe,
    output logic                done_pe
);
    logic [IW-1:0] bit_idx;
    logic [IW-1:0] last_idx;
    logic          par_acc;

    // Index of the final data bit for the configured length.
    always_comb begin
        if (cfg_char_len > LEN_W'(MAX_DATA - MIN_DATA))
            last_idx = IW'(MAX_DATA - 1);
        else
            last_idx = IW'(cfg_char_len) + IW'(MIN_DATA - 1);
    end

    // Bit sequencing and field capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            phase     <= '0;
            bit_idx   <= '0;
            par_acc   <= 1'b0;
            done      <= 1'b0;
            done_data <= '0;
            done_mark <= 1'b0;
            done_fe   <= 1'b0;
            done_pe   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (state == S_IDLE) begin
                    if (!line_s) begin
                        state <= S_START;
                        phase <= CW'(1);
                    end
                end else begin
                    phase <= phase + CW'(1);
                    if (vote_vld) begin
                        unique case (state)
                            S_START: begin
                                if (vote_bit) begin
                                    state <= S_IDLE;
                                end else begin
                                    state     <= S_DATA;
                                    bit_idx   <= '0;
                                    par_acc   <= 1'b0;
                                    done_data <= '0;
                                    done_mark <= 1'b0;
                                    done_pe   <= 1'b0;
                                end
                            end
                            S_DATA: begin
                                done_data[bit_idx] <= vote_bit;
                                par_acc            <= par_acc ^ vote_bit;
                                if (bit_idx == last_idx) begin
                                    if (cfg_mp_en)       state <= S_MARK;
                                    else if (cfg_par_en) state <= S_PAR;
                                    else                 state <= S_STOP;
                                end else begin
                                    bit_idx <= bit_idx + IW'(1);
                                end
                            end
                            S_MARK: begin
                                done_mark <= vote_bit;
                                state     <= cfg_par_en ? S_PAR : S_STOP;
                            end
                            S_PAR: begin
                                done_pe <= vote_bit ^ par_acc ^ cfg_par_odd;
                                state   <= S_STOP;
                            end
                            S_STOP: begin
                                done    <= 1'b1;
                                done_fe <= ~vote_bit;
                                state   <= S_IDLE;
                            end
                            default: state <= S_IDLE;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rx_entry_buf.sv
// Receive buffer: a DEPTH-entry circular queue of characters with
// per-entry flags. It can mark the newest entry as overrun.
// Assumes: push and ovr_mark are never raised together; pushes only when not full
// or when a pop happens in the same cycle.
module rx_entry_buf
    import mp_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 2,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned FW   = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      pop,
    input  logic      ovr_mark,
    output rx_entry_t head,
    output logic [FW-1:0] fill
);
    rx_entry_t     mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] newest;
    logic          pop_eff;

    // Wrap-around pointer arithmetic for any depth.
    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        pop_eff = pop && (fill != '0);
        newest  = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - PW'(1);
        head    = mem[rd_ptr];
    end

    // Storage, pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_entry;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (ovr_mark) mem[newest].overrun <= 1'b1;
            if (pop_eff) rd_ptr <= nxt(rd_ptr);
            if (push && !pop_eff)      fill <= fill + FW'(1);
            else if (!push && pop_eff) fill <= fill - FW'(1);
        end
    end
endmodule

// File: rtl/mp_serial_rx.sv
// Filtering asynchronous receiver with multiprocessor address filtering.
// Chains line filter, frame engine and receive buffer. It decides which
// completed frames are stored and tracks the address-match window.
// Assumes: os_tick pulses OS_RATE times per bit; ADDR_W <= MAX_DATA.
module mp_serial_rx
    import mp_rx_pkg::*;
#(
    parameter int unsigned OS_RATE = 16,
    parameter int unsigned DEPTH   = 2,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned LEN_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_line,
    input  logic                os_tick,
    input  logic [LEN_W-1:0]    cfg_char_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_mp_en,
    input  logic [ADDR_W-1:0]   cfg_node_addr,
    input  logic                rd_strobe,
    output logic [MAX_DATA-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_frame_err,
    output logic                rx_par_err,
    output logic                rx_overrun
);
    localparam int unsigned CW = $clog2(OS_RATE);
    localparam int unsigned FW = $clog2(DEPTH + 1);

    logic                line_s;
    logic                vote_vld;
    logic                vote_bit;
    logic [CW-1:0]       phase;
    rx_state_e           eng_state;
    logic                frm_done;
    logic [MAX_DATA-1:0] frm_data;
    logic                frm_mark;
    logic                frm_fe;
    logic                frm_pe;
    logic                matched;
    logic                store_req;
    logic                accept;
    logic                ovr_mark;
    rx_entry_t           new_entry;
    rx_entry_t           head;
    logic [FW-1:0]       buf_fill;

    rx_line_filter #(.OS_RATE(OS_RATE), .SYNC_STAGES(2)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (rx_line),
        .tick     (os_tick),
        .phase    (phase),
        .line_s   (line_s),
        .vote_vld (vote_vld),
        .vote_bit (vote_bit)
    );

    rx_frame_engine #(.OS_RATE(OS_RATE), .LEN_W(LEN_W)) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (os_tick),
        .line_s       (line_s),
        .vote_vld     (vote_vld),
        .vote_bit     (vote_bit),
        .cfg_char_len (cfg_char_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_mp_en    (cfg_mp_en),
        .phase        (phase),
        .state        (eng_state),
        .done         (frm_done),
        .done_data    (frm_data),
        .done_mark    (frm_mark),
        .done_fe      (frm_fe),
        .done_pe      (frm_pe)
    );

    // Address window: opened by a clean matching address, closed by any other.
    always_ff @(posedge clk) begin
        if (!rst_n)                  matched <= 1'b0;
        else if (!cfg_mp_en)         matched <= 1'b0;
        else if (frm_done && frm_mark)
            matched <= !frm_fe && !frm_pe && (frm_data[ADDR_W-1:0] == cfg_node_addr);
    end

    // Store decision and overrun detection.
    always_comb begin
        store_req = frm_done && (!cfg_mp_en || (!frm_mark && matched));
        accept    = store_req && ((buf_fill != FW'(DEPTH)) || (rd_strobe && buf_fill != '0));
        ovr_mark  = store_req && !accept;
        new_entry = '{data: frm_data, frame_err: frm_fe, par_err: frm_pe, overrun: 1'b0};
    end

    rx_entry_buf #(.DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (accept),
        .push_entry (new_entry),
        .pop        (rd_strobe),
        .ovr_mark   (ovr_mark),
        .head       (head),
        .fill       (buf_fill)
    );

    // Present the oldest entry, zero when empty.
    always_comb begin
        rx_valid     = (buf_fill != '0);
        rx_data      = rx_valid ? head.data : '0;
        rx_frame_err = rx_valid && head.frame_err;
        rx_par_err   = rx_valid && head.par_err;
        rx_overrun   = rx_valid && head.overrun;
    end
endmodule

// File: rtl/mp_serial_rx_chk.sv
// Cycle-level properties of the receiver, attached by bind.
module mp_serial_rx_chk
    import mp_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned FW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_strobe,
    input logic          rx_valid,
    input rx_state_e     state,
    input logic          vote_vld,
    input logic          vote_bit,
    input logic          done,
    input logic          done_mark,
    input logic          cfg_mp_en,
    input logic [FW-1:0] fill,
    input logic          store_req
);
    p_hold_until_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rd_strobe |=> rx_valid);

    p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(DEPTH));

    p_false_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START) && vote_vld && vote_bit |=> (state == S_IDLE));

    p_addr_not_stored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && cfg_mp_en && done_mark && !rd_strobe |=> $stable(fill));

    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        store_req && (fill == FW'(DEPTH)) && !rd_strobe |=> (fill == FW'(DEPTH)));
endmodule

bind mp_serial_rx mp_serial_rx_chk #(.DEPTH(DEPTH), .FW(FW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (rd_strobe),
    .rx_valid  (rx_valid),
    .state     (eng_state),
    .vote_vld  (vote_vld),
    .vote_bit  (vote_bit),
    .done      (frm_done),
    .done_mark (frm_mark),
    .cfg_mp_en (cfg_mp_en),
    .fill      (buf_fill),
    .store_req (store_req)
);

// File: tb/mp_serial_rx_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: sender tasks push expected characters, a monitor
// pops and compares every character the receiver presents.
module mp_serial_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic [2:0] cfg_char_len = 3'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_mp_en = 1'b0;
    logic [7:0] cfg_node_addr = 8'h42;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid, rx_frame_err, rx_par_err, rx_overrun;

    int n_chk = 0;
    int n_bad = 0;
    bit auto_rd = 1'b1;
    int tcnt = 0;

    typedef struct {
        logic [8:0] d;
        logic       fe;
        logic       pe;
        logic       ov;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    mp_serial_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
        .cfg_char_len(cfg_char_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_mp_en(cfg_mp_en),
        .cfg_node_addr(cfg_node_addr), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
        .rx_par_err(rx_par_err), .rx_overrun(rx_overrun)
    );

    always #2 clk = ~clk;

    // Sample tick: one pulse every four clocks.
    initial forever begin
        @(negedge clk);
        tcnt    = (tcnt + 1) % 4;
        os_tick = (tcnt == 0);
    end

    task automatic next_tick();
        @(posedge clk);
        while (!os_tick) @(posedge clk);
        @(negedge clk);
    endtask

    // One bit period; optional inverted sample 7 and early return high.
    task automatic bit_out(input logic v, input bit gl, input int high_from);
        for (int t = 0; t < 16; t++) begin
            logic val;
            val = v;
            if (gl && t == 7) val = ~v;
            if (high_from > 0 && t >= high_from) val = 1'b1;
            rx_line = val;
            next_tick();
        end
    endtask

    task automatic send(input logic [8:0] d, input bit mark, input bit bad_par,
                        input bit bad_stop, input bit gl, input int nstop, input int gap);
        int  nb;
        logic p;
        nb = (cfg_char_len > 3'd4) ? 9 : cfg_char_len + 5;
        p  = cfg_par_odd ^ bad_par;
        bit_out(1'b0, 1'b0, 0);
        for (int i = 0; i < nb; i++) begin
            bit_out(d[i], gl, 0);
            p = p ^ d[i];
        end
        if (cfg_mp_en) bit_out(mark, 1'b0, 0);
        if (cfg_par_en) bit_out(p, 1'b0, 0);
        if (bad_stop) bit_out(1'b0, 1'b0, 9);
        else          bit_out(1'b1, 1'b0, 0);
        if (nstop == 2) bit_out(1'b1, 1'b0, 0);
        for (int g = 0; g < gap; g++) bit_out(1'b1, 1'b0, 0);
    endtask

    task automatic expect_chr(input logic [8:0] d, input logic fe, input logic pe,
                              input logic ov, input string tag);
        exp_t e;
        e.d = d; e.fe = fe; e.pe = pe; e.ov = ov; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic check_quiet(input string tag);
        repeat (8) @(negedge clk);
        n_chk++;
        if (rx_valid !== 1'b0 || exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL %s: rx_valid=%b pending=%0d expected rx_valid=0 pending=0",
                     tag, rx_valid, exp_q.size());
        end
    endtask

    // Monitor: compare each presented character with the queue head.
    initial forever begin
        @(negedge clk);
        if (rd_strobe) begin
            rd_strobe = 1'b0;
        end else if (auto_rd && rx_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected character: got data=%h fe=%b pe=%b ov=%b expected none",
                         rx_data, rx_frame_err, rx_par_err, rx_overrun);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rx_data !== e.d || rx_frame_err !== e.fe ||
                    rx_par_err !== e.pe || rx_overrun !== e.ov) begin
                    n_bad++;
                    $display("FAIL %s: got data=%h fe=%b pe=%b ov=%b expected data=%h fe=%b pe=%b ov=%b",
                             e.tag, rx_data, rx_frame_err, rx_par_err, rx_overrun,
                             e.d, e.fe, e.pe, e.ov);
                end
            end
            rd_strobe = 1'b1;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        n_chk++;
        if (rx_valid !== 1'b0 || rx_data !== 9'h0 || rx_frame_err !== 1'b0 ||
            rx_par_err !== 1'b0 || rx_overrun !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: valid=%b data=%h fe=%b pe=%b ov=%b expected all 0",
                     rx_valid, rx_data, rx_frame_err, rx_par_err, rx_overrun);
        end
        bit_out(1'b1, 1'b0, 0);

        // R2: 8-bit characters, then 5, 6, 7 and 9 bits.
        expect_chr(9'h0A5, 0, 0, 0, "R2 len8 a5"); send(9'h0A5, 0, 0, 0, 0, 1, 1);
        expect_chr(9'h03C, 0, 0, 0, "R2 len8 3c"); send(9'h03C, 0, 0, 0, 0, 1, 1);
        cfg_char_len = 3'd0;
        expect_chr(9'h015, 0, 0, 0, "R2 len5"); send(9'h1F5, 0, 0, 0, 0, 1, 1);
        cfg_char_len = 3'd1;
        expect_chr(9'h02A, 0, 0, 0, "R2 len6"); send(9'h0EA, 0, 0, 0, 0, 1, 1);
        cfg_char_len = 3'd2;
        expect_chr(9'h055, 0, 0, 0, "R2 len7"); send(9'h0D5, 0, 0, 0, 0, 1, 1);
        cfg_char_len = 3'd4;
        expect_chr(9'h1C3, 0, 0, 0, "R2 len9"); send(9'h1C3, 0, 0, 0, 0, 1, 1);
        cfg_char_len = 3'd7;
        expect_chr(9'h12D, 0, 0, 0, "R2 len code 7"); send(9'h12D, 0, 0, 0, 0, 1, 1);
        cfg_char_len = 3'd3;

        // R3: sample 7 of every bit inverted.
        expect_chr(9'h096, 0, 0, 0, "R3 glitch"); send(9'h096, 0, 0, 0, 1, 1, 1);

        // R4: short low pulse rejected, then a normal frame.
        bit_out(1'b0, 1'b0, 4);
        bit_out(1'b1, 1'b0, 0);
        check_quiet("R4 false start");
        expect_chr(9'h05A, 0, 0, 0, "R4 after false start"); send(9'h05A, 0, 0, 0, 0, 1, 1);

        // R5: parity, even and odd, good and bad.
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        expect_chr(9'h0B7, 0, 0, 0, "R5 even ok");  send(9'h0B7, 0, 0, 0, 0, 1, 1);
        expect_chr(9'h0B7, 0, 1, 0, "R5 even bad"); send(9'h0B7, 0, 1, 0, 0, 1, 1);
        cfg_par_odd = 1'b1;
        expect_chr(9'h031, 0, 0, 0, "R5 odd ok");   send(9'h031, 0, 0, 0, 0, 1, 1);
        expect_chr(9'h031, 0, 1, 0, "R5 odd bad");  send(9'h031, 0, 1, 0, 0, 1, 1);
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

        // R6: low first stop bit.
        expect_chr(9'h0C9, 1, 0, 0, "R6 frame error"); send(9'h0C9, 0, 0, 1, 0, 1, 1);

        // R7: two stop bits, back to back.
        expect_chr(9'h011, 0, 0, 0, "R7 two stop a"); send(9'h011, 0, 0, 0, 0, 2, 0);
        expect_chr(9'h0EE, 0, 0, 0, "R7 two stop b"); send(9'h0EE, 0, 0, 0, 0, 2, 0);
        expect_chr(9'h07F, 0, 0, 0, "R7 two stop c"); send(9'h07F, 0, 0, 0, 0, 2, 1);

        // R8: read while empty has no effect.
        @(negedge clk); auto_rd = 1'b0; rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        check_quiet("R8 read on empty");

        // R8 and R9: fill both entries, hold, then overflow.
        send(9'h0A1, 0, 0, 0, 0, 1, 1);
        send(9'h0B2, 0, 0, 0, 0, 1, 1);
        repeat (200) @(negedge clk);
        n_chk++;
        if (rx_valid !== 1'b1 || rx_data !== 9'h0A1) begin
            n_bad++;
            $display("FAIL R8 hold: valid=%b data=%h expected valid=1 data=0a1", rx_valid, rx_data);
        end
        send(9'h0C3, 0, 0, 0, 0, 1, 1);
        expect_chr(9'h0A1, 0, 0, 0, "R9 oldest keeps flag clear");
        expect_chr(9'h0B2, 0, 0, 1, "R9 newest marked overrun");
        auto_rd = 1'b1;
        check_quiet("R9 dropped character");

        // R10, R11: multiprocessor addressing.
        cfg_mp_en = 1'b1;
        send(9'h077, 0, 0, 0, 0, 1, 1);
        check_quiet("R11 closed at start");
        send(9'h013, 1, 0, 0, 0, 1, 1);
        send(9'h078, 0, 0, 0, 0, 1, 1);
        check_quiet("R11 other address");
        send(9'h042, 1, 0, 0, 0, 1, 1);
        check_quiet("R10 address not stored");
        expect_chr(9'h011, 0, 0, 0, "R10 matched data 1"); send(9'h011, 0, 0, 0, 0, 1, 1);
        expect_chr(9'h022, 0, 0, 0, "R10 matched data 2"); send(9'h022, 0, 0, 0, 0, 1, 1);
        send(9'h042, 1, 0, 1, 0, 1, 1);
        send(9'h033, 0, 0, 0, 0, 1, 1);
        check_quiet("R11 errored address closes");
        send(9'h042, 1, 0, 0, 0, 1, 1);
        expect_chr(9'h044, 0, 0, 0, "R11 reopened"); send(9'h044, 0, 0, 0, 0, 1, 1);
        send(9'h099, 1, 0, 0, 0, 1, 1);
        send(9'h055, 0, 0, 0, 0, 1, 1);
        check_quiet("R11 mismatch closes");

        // R12: addressing off, every frame stored.
        cfg_mp_en = 1'b0;
        expect_chr(9'h066, 0, 0, 0, "R12 mp off"); send(9'h066, 0, 0, 0, 0, 1, 1);
        check_quiet("R12 drained");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule